// File: doc/BRIEF.md
# Cache Interconnect Performance Counter Unit

This block counts cache traffic events for a cache interconnect. Eight single-cycle event strobes come in from the cache logic. Sixteen 64-bit event counters each watch one of those strobes, picked by a 32-bit event code that software programs. A dedicated 64-bit cycle counter counts clocks. Software reaches every register through a simple register port: 64-bit write data with a write strobe, and a combinational read path selected by a read address.

Software typically works in this order:
1. Program the event codes.
2. Preload each counter, often to half of full scale so that interrupt latency has plenty of slack.
3. Enable the interrupts it wants.
4. Set the global enable.

When a counter wraps past all-ones, its bit in a 64-bit overflow bitmap is set. Event counter n owns bit n and the cycle counter owns bit 63. The interrupt line is a level: it stays high while any overflow bit that is also enabled remains set. Software clears overflow bits by writing ones to them.

All ports are plain control and status pins. None of them carries a data stream, so there is no valid/ready handshake and no back-pressure: a write is accepted in the cycle its strobe is high, and read data always follows the read address.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every register reads zero, every counter is zero, global enable is off and `irq` is low.
- R2: Registers sit at these byte offsets: control 0x040, overflow status 0x048, interrupt enable 0x050, cycle counter 0x058, event select n at 0x060+8n, event counter n at 0x160+8n. Any other offset, including any offset that is not a multiple of 8, reads zero and ignores writes.
- R3: While control bit 0 (global enable) is 1, the cycle counter adds one every clock. While it is 0, the cycle counter holds its value.
- R4: While global enable is 1, event counter n adds one in each cycle where the strobe selected by its code is high. The strobe bits are: 0 read request (0x04000701), 1 write request (0x03000001), 2 release request (0x0003e001), 3 read hit (0x00901202), 4 read miss (0x04008002), 5 write hit (0x006c0002), 6 write miss (0x03000002), 7 writeback (0x00000403). Code 0x058 counts every enabled cycle. Any other code never counts.
- R5: A software write to any counter sets its value on the next clock edge. If an increment falls in the same cycle, the write wins.
- R6: Writing 1 to an overflow status bit clears it. Writing 0 leaves it as it was.
- R7: When a counter wraps from all-ones to zero, its overflow bit is set on the same edge: bit n for event counter n, bit 63 for the cycle counter. If a wrap and a software clear of the same bit fall in the same cycle, the bit ends up set.
- R8: `irq` is high exactly while at least one overflow status bit is set together with its interrupt enable bit.
- R9: The interrupt enable and overflow status registers hold only bits 0..15 and bit 63; their other bits read zero. The control register holds only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 64 | Write data |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 64 | Read data, combinational from `rd_addr` |
| evt_strobe | input | 8 | Cache event strobes, one bit per event (bit map in R4) |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a counter wrap that lands in the same cycle as a software write-one-to-clear of that counter's own overflow bit. Reaching it needs the bit already set, the counter reloaded to all-ones, counting enabled, the matching strobe raised and the clear issued, all on one clock edge. The bench reaches it with a directed sequence that preloads all-ones and raises the strobe together with the status write. Random strobe patterns over counters programmed with random codes, including the all-cycles code and an unknown code, cover the event matching.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  // register byte offsets (software decodes these)
  localparam int OFF_CTRL     = 'h040;
  localparam int OFF_OVF      = 'h048;
  localparam int OFF_IEN      = 'h050;
  localparam int OFF_CYC      = 'h058;
  localparam int OFF_SEL_BASE = 'h060;
  localparam int OFF_CNT_BASE = 'h160;

  localparam int NUM_EVT = 8;
  localparam int CODE_W  = 32;

  // strobe bit positions
  typedef enum int {
    EV_RD_REQ = 0, EV_WR_REQ = 1, EV_REL_REQ = 2, EV_RD_HIT = 3,
    EV_RD_MISS = 4, EV_WR_HIT = 5, EV_WR_MISS = 6, EV_WBACK = 7
  } evt_bit_e;

  localparam logic [CODE_W-1:0] CODE_CYCLES  = 32'h0000_0058;
  localparam logic [CODE_W-1:0] CODE_RD_REQ  = 32'h0400_0701;
  localparam logic [CODE_W-1:0] CODE_WR_REQ  = 32'h0300_0001;
  localparam logic [CODE_W-1:0] CODE_REL_REQ = 32'h0003_e001;
  localparam logic [CODE_W-1:0] CODE_RD_HIT  = 32'h0090_1202;
  localparam logic [CODE_W-1:0] CODE_RD_MISS = 32'h0400_8002;
  localparam logic [CODE_W-1:0] CODE_WR_HIT  = 32'h006c_0002;
  localparam logic [CODE_W-1:0] CODE_WR_MISS = 32'h0300_0002;
  localparam logic [CODE_W-1:0] CODE_WBACK   = 32'h0000_0403;
endpackage

// File: rtl/pmu_evt_match.sv
module pmu_evt_match
  import perf_mon_pkg::*;
(
  input  logic [CODE_W-1:0]  code,
  input  logic [NUM_EVT-1:0] strobe,
  output logic               hit
);
  always_comb begin
    unique case (code)
      CODE_CYCLES:  hit = 1'b1;
      CODE_RD_REQ:  hit = strobe[EV_RD_REQ];
      CODE_WR_REQ:  hit = strobe[EV_WR_REQ];
      CODE_REL_REQ: hit = strobe[EV_REL_REQ];
      CODE_RD_HIT:  hit = strobe[EV_RD_HIT];
      CODE_RD_MISS: hit = strobe[EV_RD_MISS];
      CODE_WR_HIT:  hit = strobe[EV_WR_HIT];
      CODE_WR_MISS: hit = strobe[EV_WR_MISS];
      CODE_WBACK:   hit = strobe[EV_WBACK];
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);
  // a load beats a coincident increment, so no wrap is reported then
  assign wrap = inc && !load && (count == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (inc)  count <= count + W'(1);
  end
endmodule

// File: rtl/pmu_addr_dec.sv
module pmu_addr_dec
  import perf_mon_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_CNT = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ctrl,
  output logic              hit_ovf,
  output logic              hit_ien,
  output logic              hit_cyc,
  output logic              hit_sel,
  output logic              hit_cnt,
  output logic [IDX_W-1:0]  idx
);
  localparam int SPAN = 8 * NUM_CNT;

  logic              aligned;
  logic [ADDR_W-1:0] sel_off, cnt_off;

  assign aligned  = (addr[2:0] == 3'b000);
  assign sel_off  = addr - ADDR_W'(OFF_SEL_BASE);
  assign cnt_off  = addr - ADDR_W'(OFF_CNT_BASE);

  assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign hit_ovf  = (addr == ADDR_W'(OFF_OVF));
  assign hit_ien  = (addr == ADDR_W'(OFF_IEN));
  assign hit_cyc  = (addr == ADDR_W'(OFF_CYC));
  assign hit_sel  = aligned && (addr >= ADDR_W'(OFF_SEL_BASE)) && (sel_off < ADDR_W'(SPAN));
  assign hit_cnt  = aligned && (addr >= ADDR_W'(OFF_CNT_BASE)) && (cnt_off < ADDR_W'(SPAN));

  always_comb begin
    if (hit_sel) idx = sel_off[IDX_W+2:3];
    else         idx = cnt_off[IDX_W+2:3];
  end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import perf_mon_pkg::*;
#(
  parameter int NUM_CNT = 16,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_EVT-1:0] evt_strobe,
  output logic               irq
);
  localparam int IDX_W   = $clog2(NUM_CNT);
  localparam int CYC_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CNT) - DATA_W'(1));

  logic              w_ctrl, w_ovf, w_ien, w_cyc, w_sel, w_cnt;
  logic              r_ctrl, r_ovf, r_ien, r_cyc, r_sel, r_cnt;
  logic [IDX_W-1:0]  w_idx, r_idx;

  pmu_addr_dec #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .IDX_W(IDX_W)) u_wdec (
    .addr(wr_addr), .hit_ctrl(w_ctrl), .hit_ovf(w_ovf), .hit_ien(w_ien),
    .hit_cyc(w_cyc), .hit_sel(w_sel), .hit_cnt(w_cnt), .idx(w_idx));

  pmu_addr_dec #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .IDX_W(IDX_W)) u_rdec (
    .addr(rd_addr), .hit_ctrl(r_ctrl), .hit_ovf(r_ovf), .hit_ien(r_ien),
    .hit_cyc(r_cyc), .hit_sel(r_sel), .hit_cnt(r_cnt), .idx(r_idx));

  logic              en_q;
  logic [DATA_W-1:0] ien_q, ovf_q, set_vec;
  logic [DATA_W-1:0] cyc_q;
  logic              cyc_wrap;
  logic [CODE_W-1:0] sel_q [NUM_CNT];
  logic [DATA_W-1:0] cnt_q [NUM_CNT];
  logic [NUM_CNT-1:0] ev_wrap;

  // control and interrupt enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ien_q <= '0;
    end else begin
      if (wr_en && w_ctrl) en_q  <= wr_data[0];
      if (wr_en && w_ien)  ien_q <= wr_data & IMPL_MASK;
    end
  end

  // event counters with their selectors
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_evt
    logic hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   sel_q[g] <= '0;
      else if (wr_en && w_sel && w_idx == IDX_W'(g)) sel_q[g] <= wr_data[CODE_W-1:0];
    end

    pmu_evt_match u_match (.code(sel_q[g]), .strobe(evt_strobe), .hit(hit));

    pmu_counter #(.W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en && w_cnt && w_idx == IDX_W'(g)), .load_val(wr_data),
      .inc(en_q && hit), .count(cnt_q[g]), .wrap(ev_wrap[g]));
  end

  pmu_counter #(.W(DATA_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .load(wr_en && w_cyc), .load_val(wr_data),
    .inc(en_q), .count(cyc_q), .wrap(cyc_wrap));

  // overflow status: set beats write-one-to-clear
  always_comb begin
    set_vec               = '0;
    set_vec[NUM_CNT-1:0]  = ev_wrap;
    set_vec[CYC_BIT]      = cyc_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= ((ovf_q & ~((wr_en && w_ovf) ? wr_data : '0)) | set_vec) & IMPL_MASK;
  end

  assign irq = |(ovf_q & ien_q);

  // read path
  always_comb begin
    rd_data = '0;
    if (r_ctrl)     rd_data = DATA_W'(en_q);
    else if (r_ovf) rd_data = ovf_q;
    else if (r_ien) rd_data = ien_q;
    else if (r_cyc) rd_data = cyc_q;
    else if (r_sel) rd_data = DATA_W'(sel_q[r_idx]);
    else if (r_cnt) rd_data = cnt_q[r_idx];
  end
endmodule

// File: rtl/perf_mon_unit_chk.sv
module perf_mon_unit_chk
  import perf_mon_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              en_q,
  input logic [DATA_W-1:0] cyc_q,
  input logic [DATA_W-1:0] ovf_q
);
  logic cyc_wr, ovf_wr, cyc_wraps;
  assign cyc_wr    = wr_en && (wr_addr == ADDR_W'(OFF_CYC));
  assign ovf_wr    = wr_en && (wr_addr == ADDR_W'(OFF_OVF));
  assign cyc_wraps = en_q && !cyc_wr && (cyc_q == {DATA_W{1'b1}});

  AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cyc_wr) |=> $stable(cyc_q)); // R3
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !cyc_wr && cyc_q != {DATA_W{1'b1}}) |=> (cyc_q == $past(cyc_q) + DATA_W'(1))); // R3
  AST_CYC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wr |=> (cyc_q == $past(wr_data))); // R5
  AST_CYC_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wraps |=> ovf_q[DATA_W-1]); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q[DATA_W-1] && !(ovf_wr && wr_data[DATA_W-1])) |=> ovf_q[DATA_W-1]); // R6
  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_wr && wr_data[DATA_W-1] && !cyc_wraps) |=> !ovf_q[DATA_W-1]); // R6
endmodule

bind perf_mon_unit perf_mon_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .en_q(en_q), .cyc_q(cyc_q), .ovf_q(ovf_q));

// File: tb/sim_perf_mon_unit.sv
module sim_perf_mon_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic [7:0]  evt_strobe = '0;
  logic        irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_mon_unit u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_strobe(evt_strobe), .irq(irq));

  function automatic logic [11:0] sel_a(int n); return 12'(32'h060 + 8*n); endfunction
  function automatic logic [11:0] cnt_a(int n); return 12'(32'h160 + 8*n); endfunction

  // code table: 0 = all cycles, 1..8 = strobe bits 0..7, 9 = unknown
  function automatic logic [31:0] code_of(int k);
    case (k)
      0: return 32'h0000_0058; 1: return 32'h0400_0701; 2: return 32'h0300_0001;
      3: return 32'h0003_e001; 4: return 32'h0090_1202; 5: return 32'h0400_8002;
      6: return 32'h006c_0002; 7: return 32'h0300_0002; 8: return 32'h0000_0403;
      default: return 32'hdead_0001;
    endcase
  endfunction
  function automatic int exp_inc(int k, logic [7:0] s);
    if (k == 0) return 1;
    if (k >= 1 && k <= 8) return int'(s[k-1]);
    return 0;
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [63:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rd_chk(string what, logic [11:0] a, logic [63:0] exp);
    logic [63:0] v;
    rd(a, v);
    chk(what, v, exp);
  endtask

  task automatic random_round(int cycles);
    int  ksel [16];
    longint unsigned exp [16];
    for (int n = 0; n < 16; n++) begin
      ksel[n] = (n == 0) ? 9 : (n == 1) ? 0 : int'($urandom % 10);
      exp[n]  = 0;
      wr(sel_a(n), {32'h0, code_of(ksel[n])});
      wr(cnt_a(n), 64'h0);
    end
    wr(12'h058, 64'h0);
    wr(12'h040, 64'h1);
    for (int c = 0; c < cycles; c++) begin
      logic [7:0] s;
      s = 8'($urandom);
      evt_strobe = s;
      for (int n = 0; n < 16; n++) exp[n] += longint'(exp_inc(ksel[n], s));
      @(negedge clk);
    end
    evt_strobe = '0;
    for (int n = 0; n < 16; n++) exp[n] += longint'(exp_inc(ksel[n], 8'h00));
    wr(12'h040, 64'h0);
    for (int n = 0; n < 16; n++)
      rd_chk($sformatf("R4 counter %0d code %h", n, code_of(ksel[n])), cnt_a(n), exp[n]);
    rd_chk("R3 cycle counter after random round", 12'h058, 64'(cycles + 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 control", 12'h040, 64'h0);
    rd_chk("R1 overflow", 12'h048, 64'h0);
    rd_chk("R1 irq enable", 12'h050, 64'h0);
    rd_chk("R1 cycle counter", 12'h058, 64'h0);
    rd_chk("R1 select 0", sel_a(0), 64'h0);
    rd_chk("R1 counter 15", cnt_a(15), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);

    // R2 unmapped and misaligned offsets
    wr(12'h100, ONES);
    rd_chk("R2 unmapped 0x100", 12'h100, 64'h0);
    wr(12'h061, 64'h5);
    rd_chk("R2 misaligned write ignored", sel_a(0), 64'h0);
    rd_chk("R2 misaligned read 0x044", 12'h044, 64'h0);
    rd_chk("R2 unmapped 0x1e0", 12'h1e0, 64'h0);
    rd_chk("R2 unmapped 0x000", 12'h000, 64'h0);

    // R3 cycle counting window: 10 idle cycles + disable cycle
    wr(12'h058, 64'd100);
    rd_chk("R5 cycle preload", 12'h058, 64'd100);
    wr(12'h040, 64'h1);
    repeat (10) @(negedge clk);
    wr(12'h040, 64'h0);
    rd_chk("R3 cycle counter counted", 12'h058, 64'd111);
    repeat (5) @(negedge clk);
    rd_chk("R3 cycle counter held when disabled", 12'h058, 64'd111);

    // R5 write beats increment
    wr(12'h040, 64'h1);
    wr(12'h058, 64'd1000);
    rd_chk("R5 cycle write over increment", 12'h058, 64'd1000);
    wr(12'h040, 64'h0);
    wr(sel_a(3), 64'h0090_1202);
    wr(12'h040, 64'h1);
    evt_strobe = 8'h08;
    wr(cnt_a(3), 64'd42);
    evt_strobe = 8'h00;
    wr(12'h040, 64'h0);
    rd_chk("R5 event write over increment", cnt_a(3), 64'd42);

    // R4 random strobe rounds
    random_round(300);
    random_round(500);

    // R7/R8 event wrap on counter 2 (write request, strobe bit 1)
    wr(12'h048, ONES);
    wr(sel_a(2), 64'h0300_0001);
    wr(cnt_a(2), ONES);
    wr(12'h050, 64'h4);
    wr(12'h040, 64'h1);
    evt_strobe = 8'h02;
    @(negedge clk);
    evt_strobe = 8'h00;
    wr(12'h040, 64'h0);
    rd_chk("R7 counter 2 wrapped to zero", cnt_a(2), 64'h0);
    rd_chk("R7 overflow bit 2 set", 12'h048, 64'h4);
    chk("R8 irq with enabled overflow", 64'(irq), 64'h1);
    wr(12'h048, 64'h0);
    rd_chk("R6 write zero keeps status", 12'h048, 64'h4);
    wr(12'h050, 64'h0);
    chk("R8 irq masked", 64'(irq), 64'h0);
    rd_chk("R8 status kept while masked", 12'h048, 64'h4);
    wr(12'h050, 64'h4);
    chk("R8 irq unmasked", 64'(irq), 64'h1);

    // R7 wrap coincides with clear: overflow wins
    wr(cnt_a(2), ONES);
    wr(12'h040, 64'h1);
    evt_strobe = 8'h02;
    wr(12'h048, 64'h4);
    evt_strobe = 8'h00;
    wr(12'h040, 64'h0);
    rd_chk("R7 wrap beats clear", 12'h048, 64'h4);
    wr(12'h048, 64'h4);
    rd_chk("R6 write one clears", 12'h048, 64'h0);
    chk("R8 irq low after clear", 64'(irq), 64'h0);

    // R7 cycle counter wrap sets bit 63
    wr(12'h050, 64'h8000_0000_0000_0000);
    wr(12'h058, ONES);
    wr(12'h040, 64'h1);
    wr(12'h040, 64'h0);
    rd_chk("R7 cycle counter wrapped", 12'h058, 64'h0);
    rd_chk("R7 overflow bit 63", 12'h048, 64'h8000_0000_0000_0000);
    chk("R8 irq from cycle overflow", 64'(irq), 64'h1);
    wr(12'h048, ONES);
    rd_chk("R6 clear bit 63", 12'h048, 64'h0);

    // R9 implemented bits only
    wr(12'h050, ONES);
    rd_chk("R9 irq enable width", 12'h050, 64'h8000_0000_0000_ffff);
    wr(12'h040, ONES);
    rd_chk("R9 control width", 12'h040, 64'h1);
    wr(12'h040, 64'h0);
    rd(12'h048, v);
    chk("R9 overflow unimplemented bits", v & 64'h7fff_ffff_ffff_0000, 64'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule